// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter that has several multiplexed inputs. Two configuration inputs set how many analog channels are enabled and which one is to be converted. A start command is accepted only when the chosen channel lies inside the enabled range. An accepted start drives the channel select to the input multiplexer and holds the sample/hold control in sample for a fixed number of clock cycles. The control then switches to hold and the block searches for the digital code one bit per cycle, starting at the most significant bit.

In each trial the block presents a tap code to the resistor string and reads one comparator bit back. The trial bit stays set when the comparator reports that the held input is at or above the tap, and is cleared when it is below. The next lower bit is then set for the following trial. When the last bit has been decided, the code is copied from the working register into a separate result register, and a one-cycle completion interrupt is raised in the same cycle. The analog parts (multiplexer, resistor string, comparator and sample/hold) are outside this block.

Top module: `sar_adc_sequencer`

## Requirements
- R1: A start is accepted only while idle and when `cfg_ch_sel` is strictly less than `cfg_ch_count`, where `cfg_ch_count` is the number of enabled channels (0 to NUM_CH). On acceptance, `mux_sel` takes the value of `cfg_ch_sel` and holds it until the next accepted start.
- R2: `sh_sample` is 1 (sample) while idle and for exactly SAMPLE_CYCLES cycles after the accepting clock edge. It is then 0 (hold) for all bit trials and returns to 1 in the cycle the result appears.
- R3: The first trial presents `tap_code` = 8'h80, which is half the reference.
- R4: When `cmp_in` is 1 (input at or above the tap) the bit under trial stays 1. When `cmp_in` is 0 it is cleared to 0.
- R5: After each decision the next lower bit is set, and the tap carries all bits already decided. The second tap is therefore 8'hC0 if bit 7 was kept and 8'h40 if it was cleared.
- R6: Exactly RES_BITS trials run, one per clock cycle, from bit 7 down to bit 0. The result appears SAMPLE_CYCLES + RES_BITS cycles after the accepting edge.
- R7: The result register receives the fully decided code. With an ideal comparator, `result` equals the held input code, including the codes 8'h00 and 8'hFF.
- R8: `irq` is high for exactly one cycle. That is the cycle in which the new `result` first appears.
- R9: `busy` is 1 from the cycle after the accepting edge until the result is latched, and is 0 in the cycle in which `irq` is high.
- R10: A start rejected by R1 leaves the block idle and sets `err`. `err` stays set until the next accepted start clears it.
- R11: A start while busy is ignored: `mux_sel`, the running conversion and `err` are unaffected. `result` keeps its previous value until a conversion completes.
- R12: Reset gives `tap_code` = 0, `result` = 0, `irq` = 0, `busy` = 0, `err` = 0, `mux_sel` = 0 and `sh_sample` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_ch_count | input | CHW+1 | Number of enabled channels |
| cfg_ch_sel | input | CHW | Channel requested for the next conversion |
| start | input | 1 | Conversion start command, sampled when idle |
| cmp_in | input | 1 | Comparator output, 1 when held input is at or above the tap |
| mux_sel | output | CHW | Channel select to the analog multiplexer |
| sh_sample | output | 1 | 1 = sample, 0 = hold |
| tap_code | output | RES_BITS | Trial code to the resistor-string tap selector |
| busy | output | 1 | Conversion in progress |
| err | output | 1 | Last start was rejected for an invalid channel |
| result | output | RES_BITS | Latched conversion result |
| irq | output | 1 | One-cycle conversion-complete pulse |

## Verification
The bench builds the block with four channels, three sample cycles and 8-bit resolution. The short sample phase lets every cycle of a conversion be checked against a computed tap sequence. The channel count is small enough that both boundary selections, the last enabled channel and the first disabled one, are reached with a count of two. A count of zero is also reached, and it rejects every start. An ideal comparator against a stored code drives `cmp_in`, so the extreme codes and alternating bit patterns exercise every keep and clear decision.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sar_ctrl_fsm.sv
module sar_ctrl_fsm
  import sar_seq_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 4,
  parameter int CHW           = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW:0]   cfg_ch_count,
  input  logic [CHW-1:0] cfg_ch_sel,
  input  logic           last_trial,
  output logic           load_first,
  output logic           trial_en,
  output logic           done,
  output logic           busy,
  output logic           sh_sample,
  output logic           err,
  output logic [CHW-1:0] mux_sel
);

  localparam int SCW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [SCW-1:0] SAMPLE_LAST = SCW'(SAMPLE_CYCLES - 1);

  seq_state_e     state_q, state_d;
  logic [SCW-1:0] cnt_q, cnt_d;
  logic [CHW-1:0] ch_q;
  logic           ch_en;
  logic           err_q, err_d, err_en;
  logic           sel_ok;

  assign sel_ok = ({1'b0, cfg_ch_sel} < cfg_ch_count);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ch_en   = 1'b0;
    err_en  = 1'b0;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          err_en = 1'b1;
          if (sel_ok) begin
            state_d = ST_SAMPLE;
            cnt_d   = '0;
            ch_en   = 1'b1;
            err_d   = 1'b0;
          end else begin
            err_d   = 1'b1;
          end
        end
      end
      ST_SAMPLE: begin
        if (cnt_q == SAMPLE_LAST) state_d = ST_CONVERT;
        else                      cnt_d   = cnt_q + 1'b1;
      end
      ST_CONVERT: begin
        if (last_trial) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (ch_en)  ch_q  <= cfg_ch_sel;
      if (err_en) err_q <= err_d;
    end
  end

  assign load_first = (state_q == ST_SAMPLE) && (cnt_q == SAMPLE_LAST);
  assign trial_en   = (state_q == ST_CONVERT);
  assign done       = trial_en && last_trial;
  assign busy       = (state_q != ST_IDLE);
  assign sh_sample  = (state_q != ST_CONVERT);
  assign err        = err_q;
  assign mux_sel    = ch_q;

  // R10: an out-of-range start while idle leaves the block idle with err raised
  assert_bad_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sel_ok) |=> (err && !busy));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_first,
  input  logic                trial_en,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] sar_q,
  output logic [RES_BITS-1:0] decided,
  output logic                last_trial
);

  localparam int PW = $clog2(RES_BITS);
  localparam int MSB = RES_BITS - 1;

  logic [PW-1:0]       ptr_q, ptr_d;
  logic                ptr_en;
  logic [RES_BITS-1:0] trial_next;
  logic [RES_BITS-1:0] sar_d;
  logic                sar_en;

  for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
    assign decided[i] = (int'(ptr_q) == i) ? (sar_q[i] & cmp_in) : sar_q[i];
    if (i == MSB) begin : g_top
      assign trial_next[i] = decided[i];
      assign sar_d[i]      = load_first ? 1'b1 : trial_next[i];
    end else begin : g_low
      assign trial_next[i] = (int'(ptr_q) == i + 1) ? 1'b1 : decided[i];
      assign sar_d[i]      = load_first ? 1'b0 : trial_next[i];
    end
  end

  assign last_trial = trial_en && (ptr_q == '0);
  assign sar_en     = load_first || trial_en;

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if (load_first) begin
      ptr_en = 1'b1;
      ptr_d  = PW'(MSB);
    end else if (trial_en && !last_trial) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      ptr_q <= '0;
    end else begin
      if (sar_en) sar_q <= sar_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // R5: every trial cycle presents a tap with a trial bit set
  assert_trial_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trial_en |-> (sar_q != '0));

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [RES_BITS-1:0] code_in,
  output logic [RES_BITS-1:0] result,
  output logic                irq
);

  logic [RES_BITS-1:0] result_q;
  logic                irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (done) result_q <= code_in;
      irq_q <= done;
    end
  end

  assign result = result_q;
  assign irq    = irq_q;

  // R8: completion pulse lasts a single cycle
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R11: result only moves in the cycle the completion pulse is shown
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> $stable(result_q));

endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer #(
  parameter int NUM_CH        = 8,
  parameter int RES_BITS      = 8,
  parameter int SAMPLE_CYCLES = 4,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHW:0]        cfg_ch_count,
  input  logic [CHW-1:0]      cfg_ch_sel,
  input  logic                start,
  input  logic                cmp_in,
  output logic [CHW-1:0]      mux_sel,
  output logic                sh_sample,
  output logic [RES_BITS-1:0] tap_code,
  output logic                busy,
  output logic                err,
  output logic [RES_BITS-1:0] result,
  output logic                irq
);

  localparam logic [RES_BITS-1:0] HALF_CODE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic                load_first;
  logic                trial_en;
  logic                done;
  logic                last_trial;
  logic [RES_BITS-1:0] decided;

  sar_ctrl_fsm #(
    .SAMPLE_CYCLES (SAMPLE_CYCLES),
    .CHW           (CHW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_ch_count (cfg_ch_count),
    .cfg_ch_sel   (cfg_ch_sel),
    .last_trial   (last_trial),
    .load_first   (load_first),
    .trial_en     (trial_en),
    .done         (done),
    .busy         (busy),
    .sh_sample    (sh_sample),
    .err          (err),
    .mux_sel      (mux_sel)
  );

  sar_bit_engine #(
    .RES_BITS (RES_BITS)
  ) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (load_first),
    .trial_en   (trial_en),
    .cmp_in     (cmp_in),
    .sar_q      (tap_code),
    .decided    (decided),
    .last_trial (last_trial)
  );

  sar_result_reg #(
    .RES_BITS (RES_BITS)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .code_in (decided),
    .result  (result),
    .irq     (irq)
  );

  // R3: entering hold coincides with the half-reference tap
  assert_first_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_sample) |-> (tap_code == HALF_CODE));

  // R9: busy has dropped whenever the completion pulse is visible
  assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  // R11: a start while busy does not disturb the channel select
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (mux_sel == $past(mux_sel)));

endmodule

// File: tb/sar_adc_sequencer_bench.sv
`timescale 1ns/1ps
module sar_adc_sequencer_bench;

  localparam int NCH  = 4;
  localparam int RB   = 8;
  localparam int SC   = 3;
  localparam int CHW  = 2;

  logic           clk;
  logic           rst_n;
  logic [CHW:0]   cfg_ch_count;
  logic [CHW-1:0] cfg_ch_sel;
  logic           start;
  logic           cmp_in;
  logic [CHW-1:0] mux_sel;
  logic           sh_sample;
  logic [RB-1:0]  tap_code;
  logic           busy;
  logic           err;
  logic [RB-1:0]  result;
  logic           irq;

  logic [RB-1:0]  ana_code;

  int checks;
  int errors;
  bit finished;

  sar_adc_sequencer #(
    .NUM_CH        (NCH),
    .RES_BITS      (RB),
    .SAMPLE_CYCLES (SC)
  ) u_sar_adc_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ch_count (cfg_ch_count),
    .cfg_ch_sel   (cfg_ch_sel),
    .start        (start),
    .cmp_in       (cmp_in),
    .mux_sel      (mux_sel),
    .sh_sample    (sh_sample),
    .tap_code     (tap_code),
    .busy         (busy),
    .err          (err),
    .result       (result),
    .irq          (irq)
  );

  // ideal comparator against the stored input code
  assign cmp_in = (ana_code >= tap_code);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    cfg_ch_count = 3'd4;
    cfg_ch_sel = '0;
    ana_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tap_code == 0, "R12", "tap_code", tap_code, 0);
    check(result == 0, "R12", "result", result, 0);
    check(irq == 0, "R12", "irq", irq, 0);
    check(busy == 0, "R12", "busy", busy, 0);
    check(err == 0, "R12", "err", err, 0);
    check(mux_sel == 0, "R12", "mux_sel", mux_sel, 0);
    check(sh_sample == 1, "R12", "sh_sample", sh_sample, 1);
  endtask

  // full conversion; optionally injects a start while busy during trial 3
  task automatic run_conv(input logic [RB-1:0] code, input int ch, input bit poke);
    logic [RB-1:0] prev;
    prev = result;
    ana_code = code;
    cfg_ch_sel = CHW'(ch);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(err == 0, "R10", "err cleared by accepted start", err, 0);
    for (int k = 0; k < SC; k++) begin
      check(sh_sample == 1, "R2", "sample phase", sh_sample, 1);
      check(busy == 1, "R9", "busy in sample", busy, 1);
      check(mux_sel == CHW'(ch), "R1", "mux_sel", mux_sel, ch);
      check(result == prev, "R11", "result held in sample", result, prev);
      @(negedge clk);
    end
    for (int b = 0; b < RB; b++) begin
      int hi;
      int exp_tap;
      hi = RB - 1 - b;
      exp_tap = (int'(code) & ((255 << (hi + 1)) & 255)) | (1 << hi);
      if (b == 0)
        check(tap_code == RB'(exp_tap), "R3", "first tap", tap_code, exp_tap);
      else if (b == 1)
        check(tap_code == RB'(exp_tap), "R5", "second tap", tap_code, exp_tap);
      else
        check(tap_code == RB'(exp_tap), "R4", "trial tap", tap_code, exp_tap);
      check(sh_sample == 0, "R2", "hold phase", sh_sample, 0);
      check(busy == 1 && irq == 0, "R6", "busy without irq in trial", {busy, irq}, 2);
      check(mux_sel == CHW'(ch), "R11", "mux_sel during trials", mux_sel, ch);
      check(result == prev, "R11", "result held in trials", result, prev);
      if (poke && b == 3) begin
        start = 1'b1;
        cfg_ch_sel = CHW'((ch + 1) % NCH);
      end
      if (poke && b == 4) begin
        start = 1'b0;
        cfg_ch_sel = CHW'(ch);
        check(err == 0, "R11", "err after busy start", err, 0);
      end
      @(negedge clk);
    end
    check(irq == 1, "R8", "irq at completion", irq, 1);
    check(result == code, "R7", "result", result, code);
    check(busy == 0, "R9", "busy at completion", busy, 0);
    check(sh_sample == 1, "R2", "sample after completion", sh_sample, 1);
    @(negedge clk);
    check(irq == 0, "R8", "irq single cycle", irq, 0);
    check(result == code, "R7", "result kept", result, code);
    check(busy == 0, "R11", "no conversion from busy start", busy, 0);
  endtask

  task automatic bad_start(input int count, input int sel);
    logic [RB-1:0]  prev_res;
    logic [CHW-1:0] prev_mux;
    prev_res = result;
    prev_mux = mux_sel;
    cfg_ch_count = (CHW+1)'(count);
    cfg_ch_sel = CHW'(sel);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(err == 1, "R10", "err after bad start", err, 1);
    check(busy == 0, "R1", "rejected start idle", busy, 0);
    check(mux_sel == prev_mux, "R1", "mux unchanged on reject", mux_sel, prev_mux);
    repeat (SC + 2) @(negedge clk);
    check(busy == 0 && sh_sample == 1, "R1", "still idle", {busy, sh_sample}, 1);
    check(irq == 0, "R10", "no irq after reject", irq, 0);
    check(result == prev_res, "R10", "result unchanged", result, prev_res);
    check(err == 1, "R10", "err sticky", err, 1);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    finished = 0;
    do_reset();
    run_conv(8'h5A, 0, 0);
    run_conv(8'h00, 1, 0);
    run_conv(8'hFF, 3, 0);
    run_conv(8'h80, 2, 0);
    run_conv(8'h7F, 0, 0);
    run_conv(8'hA5, 1, 1);
    bad_start(2, 3);
    bad_start(2, 2);
    cfg_ch_count = 3'd2;
    run_conv(8'h33, 1, 0);
    bad_start(0, 0);
    cfg_ch_count = 3'd4;
    run_conv(8'hC3, 3, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule